// File: doc/BRIEF.md
# I2C Control Register with Bus Release

This block is the control-register and bus-release stage of an I2C peripheral. It sits between a processor register port and a byte-level bus engine. The processor writes an 8-bit control word that holds a peripheral enable and two self-clearing commands: one abandons the current transfer, and one ends a clock-stretch wait. The block turns these commands into single-cycle pulses toward the engine. It owns the open-drain pull enables for SCL and SDA, the transmit/receive direction flag, a standby state and a sticky start-seen flag.

While the enable is 0 the bus engine is held in reset and every status flag is cleared. After an abandon command the block releases both lines and stays in standby, taking no part in the bus, until a start condition is seen. A start condition is SDA falling while SCL is high, sampled on the system clock. If the block is enabled while SCL is already high, SDA is already low and filtering is on, it counts a start condition at once. Firmware then answers with the abandon command.

Top module: `i2c_ctl_release`

## Requirements
- R1: After reset, rd_data is 0x00, core_rst is 1, and scl_pull, sda_pull, tx_dir, standby, start_flag, leave_pulse and wrel_pulse are all 0.
- R2: Bit 7 of the control word is the enable. A write stores wr_data[7], and rd_data[7] returns it from the next cycle. rd_data[6:0] always read 0, so the command bits read back as 0.
- R3: While the enable is 0, core_rst is 1 and tx_dir, standby, start_flag, scl_pull and sda_pull are 0. Command bits written then produce no pulse.
- R4: A write with bits 7 and 6 both set, made while enabled, is an abandon command. In the next cycle leave_pulse is 1 for exactly one cycle, standby is 1, and tx_dir, start_flag, scl_pull and sda_pull are 0.
- R5: While in standby, sda_pull stays 0, and wait requests and direction loads from the engine have no effect.
- R6: While enabled, sda_in at 0 with SCL high and sda_in at 1 in the previous cycle is a start condition. In the next cycle start_flag is 1 and standby is 0. An abandon command in the same cycle wins.
- R7: A write with bits 7 and 5 set (bit 6 clear), made while enabled, is a release-wait command. In the next cycle wrel_pulse is 1 for one cycle and scl_pull is 0.
- R8: A release-wait command during a ninth-clock wait (scl_pull=1 and eng_ninth=1) while tx_dir=1 sets tx_dir to 0 in the next cycle. Outside that case the command leaves tx_dir unchanged.
- R9: While enabled and not in standby, sda_pull follows eng_sda_low when tx_dir=1 and eng_ack_low when tx_dir=0.
- R10: A write that sets the enable from 0 while scl_in=1, sda_in=0 and filt_on=1 sets start_flag in the next cycle. With filt_on=0 it does not.
- R11: eng_wait_req while enabled and not in standby sets scl_pull in the next cycle. scl_pull then holds until a release-wait, an abandon or a disable.
- R12: eng_dir_load while enabled and not in standby loads eng_dir_val into tx_dir in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control-register write strobe |
| wr_data | input | 8 | Control-register write data |
| rd_data | output | 8 | Control-register read data |
| scl_in | input | 1 | Sampled SCL level |
| sda_in | input | 1 | Sampled SDA level |
| filt_on | input | 1 | Noise filter enabled |
| eng_wait_req | input | 1 | Engine asks to stretch SCL |
| eng_ninth | input | 1 | Engine is at the ninth clock |
| eng_dir_load | input | 1 | Engine loads direction |
| eng_dir_val | input | 1 | Direction to load (1 = transmit) |
| eng_sda_low | input | 1 | Engine data bit wants SDA low |
| eng_ack_low | input | 1 | Engine acknowledge wants SDA low |
| core_rst | output | 1 | Holds engine, shift and flag logic in reset |
| scl_pull | output | 1 | Pull SCL low (0 = released) |
| sda_pull | output | 1 | Pull SDA low (0 = released) |
| tx_dir | output | 1 | Transmit direction flag |
| standby | output | 1 | Not taking part in bus traffic |
| start_flag | output | 1 | Start condition seen |
| leave_pulse | output | 1 | One-cycle abandon pulse to engine |
| wrel_pulse | output | 1 | One-cycle release-wait pulse to engine |

## Verification
The bench targets the enable-time start rule. A design that ignored the filter input would flag a start with filtering off, and one that only watched for edges would miss the start entirely. It releases a ninth-clock wait both in transmit and in receive. A design that cleared direction on every release would lose the receive/transmit state, and one that never cleared it would keep driving SDA. It sends commands while disabled and during standby. A design that acted on them would pulse the engine or stretch the clock when it should stay silent. It also sends an abandon and a start in the same cycle, where the wrong priority would leave standby too early.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
  localparam int REG_W     = 8;
  localparam int EN_POS    = 7;
  localparam int LEAVE_POS = 6;
  localparam int WREL_POS  = 5;

  // A command bit counts only when written with the enable kept at 1
  // while the block is already enabled.
  function automatic logic cmd_hit(input logic wr, input logic en_now,
                                   input logic [REG_W-1:0] d, input int pos);
    return wr & en_now & d[EN_POS] & d[pos];
  endfunction

  // Next value of the enable bit.
  function automatic logic en_after(input logic wr, input logic en_now,
                                    input logic [REG_W-1:0] d);
    return wr ? d[EN_POS] : en_now;
  endfunction
endpackage

// File: rtl/i2cr_cmd_port.sv
module i2cr_cmd_port
  import i2cr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic             en_q,
  output logic             en_next,
  output logic             en_rise,
  output logic             leave_acc,
  output logic             wrel_acc,
  output logic             leave_pulse,
  output logic             wrel_pulse
);
  assign en_next   = en_after(wr_en, en_q, wr_data);
  assign en_rise   = wr_en & ~en_q & wr_data[EN_POS];
  assign leave_acc = cmd_hit(wr_en, en_q, wr_data, LEAVE_POS);
  // abandon outranks release-wait in the same write
  assign wrel_acc  = cmd_hit(wr_en, en_q, wr_data, WREL_POS) & ~leave_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q        <= 1'b0;
      leave_pulse <= 1'b0;
      wrel_pulse  <= 1'b0;
    end else begin
      en_q        <= en_next;
      leave_pulse <= leave_acc;
      wrel_pulse  <= wrel_acc;
    end
  end
endmodule

// File: rtl/i2cr_start_qual.sv
module i2cr_start_qual #(
  parameter bit FILT_START = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_q,
  input  logic en_rise,
  input  logic scl_in,
  input  logic sda_in,
  input  logic filt_on,
  output logic start_seen
);
  logic sda_prev;
  logic fall_ev;
  logic en_start_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sda_prev <= 1'b1;
    else        sda_prev <= sda_in;
  end

  assign fall_ev = en_q & scl_in & sda_prev & ~sda_in;

  generate
    if (FILT_START) begin : g_en_start
      assign en_start_ev = en_rise & scl_in & ~sda_in & filt_on;
    end else begin : g_no_en_start
      assign en_start_ev = 1'b0 & filt_on & en_rise;
    end
  endgenerate

  assign start_seen = fall_ev | en_start_ev;
endmodule

// File: rtl/i2cr_bus_state.sv
module i2cr_bus_state (
  input  logic clk,
  input  logic rst_n,
  input  logic en_q,
  input  logic en_next,
  input  logic leave_acc,
  input  logic wrel_acc,
  input  logic start_seen,
  input  logic wait_req,
  input  logic ninth,
  input  logic dir_load,
  input  logic dir_val,
  input  logic eng_sda_low,
  input  logic eng_ack_low,
  output logic standby,
  output logic start_flag,
  output logic tx_dir,
  output logic scl_pull,
  output logic sda_pull,
  output logic tx_drop_ev
);
  logic wait_q;
  logic active;

  assign active     = en_q & ~standby;
  assign tx_drop_ev = wrel_acc & wait_q & ninth & tx_dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      standby    <= 1'b0;
      start_flag <= 1'b0;
      tx_dir     <= 1'b0;
      wait_q     <= 1'b0;
    end else if (!en_next) begin
      standby    <= 1'b0;
      start_flag <= 1'b0;
      tx_dir     <= 1'b0;
      wait_q     <= 1'b0;
    end else if (leave_acc) begin
      standby    <= 1'b1;
      start_flag <= 1'b0;
      tx_dir     <= 1'b0;
      wait_q     <= 1'b0;
    end else begin
      if (start_seen) begin
        standby    <= 1'b0;
        start_flag <= 1'b1;
      end
      if (wrel_acc)                wait_q <= 1'b0;
      else if (wait_req && active) wait_q <= 1'b1;
      if (tx_drop_ev)              tx_dir <= 1'b0;
      else if (dir_load && active) tx_dir <= dir_val;
    end
  end

  assign scl_pull = wait_q;
  assign sda_pull = active & (tx_dir ? eng_sda_low : eng_ack_low);
endmodule

// File: rtl/i2c_ctl_release.sv
module i2c_ctl_release
  import i2cr_pkg::*;
#(
  parameter bit FILT_START = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             filt_on,
  input  logic             eng_wait_req,
  input  logic             eng_ninth,
  input  logic             eng_dir_load,
  input  logic             eng_dir_val,
  input  logic             eng_sda_low,
  input  logic             eng_ack_low,
  output logic             core_rst,
  output logic             scl_pull,
  output logic             sda_pull,
  output logic             tx_dir,
  output logic             standby,
  output logic             start_flag,
  output logic             leave_pulse,
  output logic             wrel_pulse
);
  logic en_q, en_next, en_rise;
  logic leave_acc, wrel_acc;
  logic start_seen, tx_drop_ev;

  i2cr_cmd_port u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .en_q(en_q), .en_next(en_next), .en_rise(en_rise),
    .leave_acc(leave_acc), .wrel_acc(wrel_acc),
    .leave_pulse(leave_pulse), .wrel_pulse(wrel_pulse)
  );

  i2cr_start_qual #(.FILT_START(FILT_START)) u_start (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .en_rise(en_rise),
    .scl_in(scl_in), .sda_in(sda_in), .filt_on(filt_on),
    .start_seen(start_seen)
  );

  i2cr_bus_state u_bus (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .en_next(en_next),
    .leave_acc(leave_acc), .wrel_acc(wrel_acc), .start_seen(start_seen),
    .wait_req(eng_wait_req), .ninth(eng_ninth),
    .dir_load(eng_dir_load), .dir_val(eng_dir_val),
    .eng_sda_low(eng_sda_low), .eng_ack_low(eng_ack_low),
    .standby(standby), .start_flag(start_flag), .tx_dir(tx_dir),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .tx_drop_ev(tx_drop_ev)
  );

  assign core_rst = ~en_q;
  always_comb begin
    rd_data         = '0;
    rd_data[EN_POS] = en_q;
  end
endmodule

// File: rtl/i2cr_chk.sv
module i2cr_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic en_q,
  input logic leave_acc,
  input logic wrel_acc,
  input logic start_seen,
  input logic tx_drop_ev,
  input logic standby,
  input logic start_flag,
  input logic tx_dir,
  input logic scl_pull,
  input logic sda_pull,
  input logic leave_pulse
);
  AST_DISABLED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!tx_dir && !standby && !start_flag && !scl_pull && !sda_pull)); // R3
  AST_LEAVE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    leave_acc |=> (standby && !scl_pull && !sda_pull && !tx_dir)); // R4
  AST_LEAVE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    leave_pulse |-> $past(wr_en)); // R4
  AST_STANDBY_NO_SDA: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !sda_pull); // R5
  AST_START_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (start_seen && en_q && !leave_acc && !wr_en) |=> (!standby && start_flag)); // R6
  AST_WREL_FREES_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    wrel_acc |=> !scl_pull); // R7
  AST_NINTH_TX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drop_ev |=> !tx_dir); // R8
  AST_HOLD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull |-> en_q); // R11
endmodule

bind i2c_ctl_release i2cr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .en_q(en_q),
  .leave_acc(leave_acc), .wrel_acc(wrel_acc), .start_seen(start_seen),
  .tx_drop_ev(tx_drop_ev), .standby(standby), .start_flag(start_flag),
  .tx_dir(tx_dir), .scl_pull(scl_pull), .sda_pull(sda_pull),
  .leave_pulse(leave_pulse)
);

// File: tb/sim_i2c_ctl_release.sv
module sim_i2c_ctl_release;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, scl_in = 1, sda_in = 1, filt_on = 0;
  logic [7:0] wr_data = 8'h00;
  logic wreq = 0, ninth = 0, dload = 0, dval = 0, sdal = 0, ackl = 0;
  logic [7:0] rd_data;
  logic core_rst, scl_pull, sda_pull, tx_dir, standby, start_flag;
  logic leave_pulse, wrel_pulse;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model state
  bit m_en, m_sb, m_sf, m_tx, m_wait, m_lp, m_wp, m_sdap;

  always #5 clk = ~clk;

  i2c_ctl_release u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .scl_in(scl_in), .sda_in(sda_in), .filt_on(filt_on),
    .eng_wait_req(wreq), .eng_ninth(ninth), .eng_dir_load(dload), .eng_dir_val(dval),
    .eng_sda_low(sdal), .eng_ack_low(ackl),
    .core_rst(core_rst), .scl_pull(scl_pull), .sda_pull(sda_pull), .tx_dir(tx_dir),
    .standby(standby), .start_flag(start_flag),
    .leave_pulse(leave_pulse), .wrel_pulse(wrel_pulse)
  );

  function automatic bit exp_sda();
    return m_en && !m_sb && (m_tx ? sdal : ackl);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R2 rd_data", rd_data, {m_en, 7'b0});
    chk("R3 core_rst", {7'b0, core_rst}, {7'b0, !m_en});
    chk("R4 leave_pulse", {7'b0, leave_pulse}, {7'b0, m_lp});
    chk("R5 standby", {7'b0, standby}, {7'b0, m_sb});
    chk("R6 start_flag", {7'b0, start_flag}, {7'b0, m_sf});
    chk("R7 wrel_pulse", {7'b0, wrel_pulse}, {7'b0, m_wp});
    chk("R8 tx_dir", {7'b0, tx_dir}, {7'b0, m_tx});
    chk("R9 sda_pull", {7'b0, sda_pull}, {7'b0, exp_sda()});
    chk("R11 scl_pull", {7'b0, scl_pull}, {7'b0, m_wait});
  endtask

  // one clock: inputs already set; model advanced from requirement text
  task automatic step();
    bit acc, lv, wr, en_n, act, st, rise, drop;
    acc  = wr_en && m_en && wr_data[7];
    lv   = acc && wr_data[6];
    wr   = acc && wr_data[5] && !lv;
    rise = wr_en && !m_en && wr_data[7];
    en_n = wr_en ? wr_data[7] : m_en;
    act  = m_en && !m_sb;
    st   = (m_en && scl_in && m_sdap && !sda_in) || (rise && scl_in && !sda_in && filt_on);
    drop = wr && m_wait && ninth && m_tx;
    @(posedge clk);
    #1;
    m_lp = lv; m_wp = wr; m_sdap = sda_in;
    if (!en_n) begin
      m_sb = 0; m_sf = 0; m_tx = 0; m_wait = 0;
    end else if (lv) begin
      m_sb = 1; m_sf = 0; m_tx = 0; m_wait = 0;
    end else begin
      if (st) begin m_sb = 0; m_sf = 1; end
      if (wr) m_wait = 0; else if (wreq && act) m_wait = 1;
      if (drop) m_tx = 0; else if (dload && act) m_tx = dval;
    end
    m_en = en_n;
    cmp_all();
    @(negedge clk);
    wr_en = 0; wreq = 0; dload = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1; wr_data = d;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_en = 0; m_sb = 0; m_sf = 0; m_tx = 0; m_wait = 0; m_lp = 0; m_wp = 0; m_sdap = 1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 core_rst", {7'b0, core_rst}, 8'h01);
    chk("R1 flags", {2'b0, scl_pull, sda_pull, tx_dir, standby, start_flag, leave_pulse | wrel_pulse}, 8'h00);
    @(negedge clk); rst_n = 1;

    // R10 enable with SDA low and filter on flags a start
    scl_in = 1; sda_in = 0; filt_on = 1; wr(8'h80); step();
    chk("R10 start on enable", {7'b0, start_flag}, 8'h01);
    // R3 disable clears and a leave while disabled does nothing
    wr(8'h00); step();
    wr(8'h40); step();
    chk("R3 no pulse when disabled", {6'b0, leave_pulse, start_flag}, 8'h00);
    // R10 filter off: no start
    filt_on = 0; wr(8'h80); step();
    chk("R10 no start filter off", {7'b0, start_flag}, 8'h00);
    // R6 falling SDA with SCL high
    sda_in = 1; step(); sda_in = 0; step();
    chk("R6 start detect", {7'b0, start_flag}, 8'h01);
    sda_in = 1; step();
    // R12 load transmit, R9 sda follows data
    dload = 1; dval = 1; sdal = 1; step();
    chk("R12 dir load", {7'b0, tx_dir}, 8'h01);
    chk("R9 sda data drive", {7'b0, sda_pull}, 8'h01);
    // R11 wait request
    wreq = 1; step();
    chk("R11 scl held", {7'b0, scl_pull}, 8'h01);
    // R8 release at ninth clock in transmit
    ninth = 1; wr(8'hA0); step();
    chk("R7 wrel pulse", {7'b0, wrel_pulse}, 8'h01);
    chk("R8 tx dropped", {6'b0, tx_dir, scl_pull}, 8'h00);
    step();
    chk("R7 pulse single", {7'b0, wrel_pulse}, 8'h00);
    // R8 receive-side release keeps direction
    dload = 1; dval = 0; step(); wreq = 1; step(); wr(8'hA0); step();
    chk("R8 rx keeps dir", {7'b0, tx_dir}, 8'h00);
    ninth = 0;
    // R4 leave; R6 leave beats a start in the same cycle
    dload = 1; dval = 1; wreq = 1; step();
    sda_in = 0; wr(8'hC0); step();
    chk("R4 leave standby", {5'b0, leave_pulse, standby, scl_pull}, 8'h06);
    // R5 standby ignores engine
    sda_in = 1; wreq = 1; dload = 1; dval = 1; sdal = 1; ackl = 1; step();
    chk("R5 standby ignores", {5'b0, scl_pull, tx_dir, sda_pull}, 8'h00);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit [7:0] r;
      r = 8'($urandom);
      wr_en   = ($urandom % 8) == 0;
      wr_data = {($urandom % 8) != 0, r[6:0]};
      scl_in  = ($urandom % 4) != 0;
      sda_in  = ($urandom % 3) != 0;
      filt_on = $urandom % 2;
      wreq    = ($urandom % 4) == 0;
      ninth   = $urandom % 2;
      dload   = ($urandom % 5) == 0;
      dval    = $urandom % 2;
      sdal    = $urandom % 2;
      ackl    = $urandom % 2;
      step();
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule